// File: doc/BRIEF.md
# Digital Potentiometer SPI Register Slave

This block is the serial front end and register set of a digitally controlled potentiometer. It runs on the system clock and oversamples the host's serial clock, chip select and data lines through two-flop synchronizers. Each transaction is a 24-bit frame. The first byte is a fixed identification byte. The second byte carries an operation code and a register address. The third byte is the data byte for a write, or a dummy byte during which the slave shifts out the selected register for a read.

Three registers live behind the interface. The wiper register drives the wiper position output. The power-up register is non-volatile in the real part; here it is a flop that sets the wiper at reset. The control register holds two writable bits: a select bit and an enable bit. It also shows a read-only busy flag.

The select bit decides what address 0 reaches. When it is 0, address 0 reaches the power-up register, and a write there also copies into the wiper. When it is 1, address 0 reaches the wiper register alone. A write to the power-up register starts a busy timer, and further power-up writes are dropped until the timer expires. The shutdown output combines an active-low pin with the enable bit.

Top module: `dcp_spi_regs`

## Requirements
- R1: After reset the wiper output equals NV_INIT (default 0x80), the control register reads 0x40 (select bit 7 = 0, enable bit 6 = 1, busy bit 5 = 0, bits 4:0 = 0), and SDO is 0.
- R2: A frame whose first byte is not 0x50 is ignored until CS goes high: no register changes, and SDO stays 0.
- R3: Byte two must have op code bits 7:4 equal to 1011 (read) or 1100 (write), bits 3:2 equal to 00, and address bits 1:0 equal to 00 or 10. Any other byte two makes the whole frame ignored.
- R4: With select bit 7 = 0, a write to address 00 stores the data byte in the power-up register and also in the wiper register.
- R5: With select bit 7 = 1, a write to address 00 changes only the wiper, and a read of address 00 returns the wiper. With bit 7 = 0, a read of address 00 returns the power-up register and leaves the wiper unchanged.
- R6: A power-up register write is committed when CS rises. From then, busy bit 5 reads 1 for WIP_CYCLES clock cycles and then returns to 0.
- R7: A power-up register write that ends while busy bit 5 is 1 is discarded.
- R8: A write takes effect only if exactly 24 SCK rising edges occurred while CS was low. A frame of 23 or 25 bits changes nothing.
- R9: During a read, SDO presents the selected register MSB first during the third byte. SDO changes after SCK falls and is valid before the next SCK rise. SDO is 0 outside a valid read.
- R10: The shutdown output is 1 when the shutdown pin is low or enable bit 6 is 0, and 0 otherwise.
- R11: A write to address 10 sets control bits 7 and 6 from the data byte. Bit 5 stays the busy flag, and bits 4:0 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from host (mode 0) |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| shdn_n | input | 1 | Active-low shutdown pin |
| wiper | output | 8 | Wiper position (wiper register) |
| shutdown | output | 1 | Combined shutdown request |

## Verification
The main function is exercised with four kinds of frame:
- **Valid frames** to each register, under both values of the select bit. These tell apart volatile and non-volatile routing of address 0.
- **Frames with a wrong identification byte, op code, reserved bits or address.** These separate a rejected frame from a decoded one.
- **Frames of 23 and 25 bits.** These separate a complete frame from a truncated or overlong one.
- **Back-to-back power-up writes.** Reading the busy flag before and after the timer shows whether the second write was blocked.

Both shutdown sources are toggled on their own to show that either one alone asserts the output.

// File: rtl/dcp_spi_regs.sv
module dcp_spi_regs #(
  parameter int          WIP_CYCLES = 200000,
  parameter logic [7:0]  NV_INIT    = 8'h80,
  parameter logic [7:0]  ID_BYTE    = 8'h50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       sdi,
  output logic       sdo,
  input  logic       shdn_n,
  output logic [7:0] wiper,
  output logic       shutdown
);
  localparam int         WW    = $clog2(WIP_CYCLES + 1);
  localparam logic [3:0] OP_RD = 4'b1011;
  localparam logic [3:0] OP_WR = 4'b1100;

  logic [2:0] sck_q, cs_q;
  logic [1:0] sdi_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      cs_q  <= '1;
      sdi_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      cs_q  <= {cs_q[1:0], cs_n};
      sdi_q <= {sdi_q[0], sdi};
    end

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire cs_rise  = cs_q[1] & ~cs_q[2];
  wire sel      = ~cs_q[1];

  logic [4:0] cnt;
  logic [7:0] sh, data;
  logic [1:0] addr;
  logic       bad, is_rd, is_wr;

  wire [7:0] byte_in = {sh[6:0], sdi_q[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= '0;
      sh    <= '0;
      data  <= '0;
      addr  <= '0;
      bad   <= 1'b0;
      is_rd <= 1'b0;
      is_wr <= 1'b0;
    end else if (!sel) begin
      cnt   <= '0;
      bad   <= 1'b0;
      is_rd <= 1'b0;
      is_wr <= 1'b0;
    end else if (sck_rise) begin
      sh <= byte_in;
      if (cnt != 5'd31) cnt <= cnt + 5'd1;
      if (cnt == 5'd7 && byte_in != ID_BYTE) bad <= 1'b1;
      if (cnt == 5'd15) begin
        addr  <= byte_in[1:0];
        is_rd <= byte_in[7:4] == OP_RD;
        is_wr <= byte_in[7:4] == OP_WR;
        if (byte_in[3:2] != 2'b00 || byte_in[0] ||
            (byte_in[7:4] != OP_RD && byte_in[7:4] != OP_WR))
          bad <= 1'b1;
      end
      if (cnt == 5'd23) data <= byte_in;
    end

  logic          acr_vol, acr_on;
  logic [7:0]    nv, wr;
  logic [WW-1:0] wip_cnt;

  wire wip     = wip_cnt != '0;
  wire tgt_acr = addr == 2'b10;
  wire commit  = cs_rise && cnt == 5'd24 && !bad && is_wr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acr_vol <= 1'b0;
      acr_on  <= 1'b1;
      nv      <= NV_INIT;
      wr      <= NV_INIT;
      wip_cnt <= '0;
    end else begin
      if (wip) wip_cnt <= wip_cnt - 1'b1;
      if (commit) begin
        if (tgt_acr) begin
          acr_vol <= data[7];
          acr_on  <= data[6];
        end else if (acr_vol) begin
          wr <= data;
        end else if (!wip) begin
          nv      <= data;
          wr      <= data;
          wip_cnt <= WW'(WIP_CYCLES);
        end
      end
    end

  wire [7:0] acr_rd = {acr_vol, acr_on, wip, 5'b0};
  wire [7:0] rd_val = tgt_acr ? acr_rd : (acr_vol ? wr : nv);
  wire [4:0] rem    = 5'd23 - cnt;
  wire       rd_win = is_rd && !bad && cnt >= 5'd16 && cnt <= 5'd23;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        sdo <= 1'b0;
    else if (!sel)     sdo <= 1'b0;
    else if (sck_fall) sdo <= rd_win ? rd_val[rem[2:0]] : 1'b0;

  assign wiper    = wr;
  assign shutdown = ~shdn_n | ~acr_on;
endmodule

module dcp_spi_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sdo,
  input logic       is_rd,
  input logic       bad,
  input logic       cs_rise,
  input logic [4:0] cnt,
  input logic       wip,
  input logic [7:0] nv,
  input logic [7:0] wr,
  input logic       acr_vol,
  input logic       acr_on
);
  p_sdo_read_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sdo |-> $past(is_rd && !bad));
  p_nv_loads_wiper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nv) |-> wr == nv);
  p_nv_held_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nv) |-> !$past(wip));
  p_ctrl_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({acr_vol, acr_on}) |-> ($past(cs_rise) && $past(cnt) == 5'd24));
  p_busy_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(cs_rise));
endmodule

bind dcp_spi_regs dcp_spi_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sdo(sdo), .is_rd(is_rd), .bad(bad),
  .cs_rise(cs_rise), .cnt(cnt), .wip(wip), .nv(nv), .wr(wr),
  .acr_vol(acr_vol), .acr_on(acr_on)
);

// File: tb/tb_dcp_spi_regs.sv
module tb_dcp_spi_regs;
  localparam int WIP  = 800;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0, shdn_n = 1'b1;
  logic sdo, shutdown;
  logic [7:0] wiper;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  dcp_spi_regs #(.WIP_CYCLES(WIP), .NV_INIT(8'h80)) dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .shdn_n(shdn_n), .wiper(wiper), .shutdown(shutdown));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic spi(input logic [7:0] b0, b1, b2, input int nbits, output logic [7:0] rd);
    logic [23:0] f;
    f  = {b0, b1, b2};
    rd = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 24) ? f[23-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i >= 16 && i < 24) rd[23-i] = sdo;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    spi(8'h50, {4'b1011, 2'b00, a}, 8'h00, 24, v);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] junk;
    spi(8'h50, {4'b1100, 2'b00, a}, d, 24, junk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 wiper", wiper, 8'h80);
    check("R1 sdo", {7'b0, sdo}, 8'h00);
    check("R10 shutdown idle", {7'b0, shutdown}, 8'h00);
    rd_reg(2'b10, v);
    check("R1 ctrl", v, 8'h40);
    rd_reg(2'b00, v);
    check("R9 read nv", v, 8'h80);
  endtask

  task automatic t_bad_id;
    logic [7:0] v;
    spi(8'h51, 8'hC2, 8'h00, 24, v);
    check("R2 enable kept", {7'b0, shutdown}, 8'h00);
    spi(8'h51, 8'hB2, 8'h00, 24, v);
    check("R2 sdo zero", v, 8'h00);
    rd_reg(2'b10, v);
    check("R2 ctrl unchanged", v, 8'h40);
  endtask

  task automatic t_bad_instr;
    logic [7:0] v;
    spi(8'h50, 8'hD2, 8'h00, 24, v);
    spi(8'h50, 8'hC6, 8'h00, 24, v);
    spi(8'h50, 8'hC1, 8'h11, 24, v);
    spi(8'h50, 8'hC3, 8'h11, 24, v);
    check("R3 ctrl unchanged", {7'b0, shutdown}, 8'h00);
    check("R3 wiper unchanged", wiper, 8'h80);
    spi(8'h50, 8'hA2, 8'h00, 24, v);
    check("R3 bad op read sdo", v, 8'h00);
    spi(8'h50, 8'hB6, 8'h00, 24, v);
    check("R3 reserved bits read sdo", v, 8'h00);
  endtask

  task automatic t_nv_write;
    logic [7:0] v;
    wr_reg(2'b00, 8'h33);
    check("R4 wiper loaded", wiper, 8'h33);
    wr_reg(2'b00, 8'h77);
    check("R7 wiper kept", wiper, 8'h33);
    rd_reg(2'b10, v);
    check("R6 busy set", v, 8'h60);
    repeat (WIP + 100) @(negedge clk);
    rd_reg(2'b10, v);
    check("R6 busy cleared", v, 8'h40);
    rd_reg(2'b00, v);
    check("R7 nv kept", v, 8'h33);
  endtask

  task automatic t_volatile;
    logic [7:0] v;
    wr_reg(2'b10, 8'hFF);
    rd_reg(2'b10, v);
    check("R11 ctrl writable bits", v, 8'hC0);
    wr_reg(2'b00, 8'h5A);
    check("R5 wiper written", wiper, 8'h5A);
    rd_reg(2'b00, v);
    check("R5 read wiper", v, 8'h5A);
    rd_reg(2'b10, v);
    check("R5 no busy", v, 8'hC0);
    wr_reg(2'b10, 8'h40);
    rd_reg(2'b00, v);
    check("R5 nv untouched", v, 8'h33);
    check("R5 nv read keeps wiper", wiper, 8'h5A);
  endtask

  task automatic t_frame_len;
    logic [7:0] v;
    spi(8'h50, 8'hC2, 8'h00, 23, v);
    check("R8 23 bits", {7'b0, shutdown}, 8'h00);
    spi(8'h50, 8'hC2, 8'h00, 25, v);
    check("R8 25 bits", {7'b0, shutdown}, 8'h00);
    rd_reg(2'b10, v);
    check("R8 ctrl", v, 8'h40);
  endtask

  task automatic t_shutdown;
    logic [7:0] v;
    shdn_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 pin low", {7'b0, shutdown}, 8'h01);
    shdn_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 pin high", {7'b0, shutdown}, 8'h00);
    wr_reg(2'b10, 8'h00);
    check("R10 bit low", {7'b0, shutdown}, 8'h01);
    rd_reg(2'b10, v);
    check("R11 ctrl zero", v, 8'h00);
    wr_reg(2'b10, 8'h40);
    check("R10 restored", {7'b0, shutdown}, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_bad_id;
    t_bad_instr;
    t_nv_write;
    t_volatile;
    t_frame_len;
    t_shutdown;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule